// File: doc/BRIEF.md
# Auto-Incrementing Packet Buffer Window

This block gives an 8-bit host access to a packet buffer RAM through a small register window. The host loads a pointer with two byte-wide writes. It then moves bytes in or out through four data-port addresses that all share that one pointer. Every data access advances the pointer by one. The host can therefore stream a run of bytes without reloading the address between them.

A direction flag in the upper pointer byte selects the mode. When the flag is clear, writes to the data ports store bytes in the buffer. When the flag is set, loading the pointer fetches the byte at the new address and the byte after it into a pair of data registers. The low register is reached at two port addresses and the high one at the other two. This pair is also presented as a 16-bit word. Reads from the data ports return the byte at the pointer in both modes. As a result, two reads at adjacent ports give a little-endian halfword.

A command byte sits at offset 0. It keeps its upper seven bits. Its lowest bit reports busy and always reads 0, because every operation in the window completes at once.

Top module: `bufwin_top`

## Requirements
- R1: After reset the pointer bytes (offsets 6 and 7), the command byte (offset 0) and the 16-bit prefetch word all read 0.
- R2: A write to offset 6 sets the pointer low byte and a write to offset 7 sets the high byte. Both read back all eight bits exactly as written. The high byte holds the upper address bits in its lowest ADDR_W-8 bits and the read flag in bit 5. Its other bits are plain storage.
- R3: With the read flag at 0, a write to any data port (offsets 8 to 11, i.e. host_addr[3:2] = 2'b10) stores the byte at the pointer address and then advances the pointer by 1.
- R4: A read of any data port returns the buffer byte at the pointer and then advances the pointer by 1, whatever the state of the read flag. Read data appears on host_rdata one clock edge after the strobe is first seen and holds until the next read.
- R5: A write to offset 6 or 7 that leaves the read flag at 1 loads prefetch_word with the byte at the new pointer in bits 7:0 and the byte at the next address in bits 15:8. It does not advance the pointer.
- R6: With the read flag at 1, writes to the data ports are ignored. The buffer and the pointer stay unchanged.
- R7: The address field wraps from its all-ones value to 0. An advance never changes the pointer's high-byte bits outside the address field. A prefetch at the last address takes its second byte from address 0.
- R8: A strobe held high for several cycles counts as one access. The pointer advances once per rising edge of host_rd or host_wr.
- R9: The command byte stores bits 7:1 of a write to offset 0, and its bit 0 always reads 0.
- R10: Reading port 8 and then port 9 (or port 10 and then 11) gives a halfword in little-endian order: the first read is the byte at the lower address.
- R11: A pointer write that leaves the read flag at 0 does not change prefetch_word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 4 | Register offset within the window |
| host_rd | input | 1 | Read strobe; one access per rising edge |
| host_wr | input | 1 | Write strobe; one access per rising edge, wins over host_rd |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| prefetch_word | output | 16 | Prefetched data pair, low byte at the pointer |

## Verification
The bench builds the block with ADDR_W = 9, a 512-byte buffer with a single upper address bit in the high pointer byte. With a single upper address bit, one high-byte write places the pointer at the last address. This brings the wrap of a data write, a data read and a prefetch within a few accesses. It also leaves most of the high byte as plain storage, so the bench can show that carries out of the address field leave those bits unchanged. Strobes held for several cycles show that the pointer advances only once per access.

// File: rtl/bufwin_pkg.sv
package bufwin_pkg;

  // Offsets whose meaning the decoder depends on.
  localparam logic [3:0] OFS_CMD    = 4'h0;
  localparam logic [3:0] OFS_PTR_LO = 4'h6;
  localparam logic [3:0] OFS_PTR_HI = 4'h7;

  // Position of the direction flag in the high pointer byte.
  localparam int FLAG_BIT = 5;

  // Data ports occupy offsets 8..11.
  function automatic logic is_data_port(input logic [3:0] ofs);
    return ofs[3:2] == 2'b10;
  endfunction

  // Command byte as seen by the host: the busy bit reads 0.
  function automatic logic [7:0] cmd_view(input logic [6:0] kept);
    return {kept, 1'b0};
  endfunction

endpackage

// File: rtl/bufwin_strobe.sv
module bufwin_strobe #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] strobe,
  output logic [N-1:0] rise
);
  logic [N-1:0] strobe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) strobe_q <= '0;
    else        strobe_q <= strobe;
  end

  for (genvar i = 0; i < N; i++) begin : g_lane
    assign rise[i] = strobe[i] & ~strobe_q[i];
  end
endmodule

// File: rtl/bufwin_ptr.sv
module bufwin_ptr #(
  parameter int ADDR_W   = 11,
  parameter int FLAG_POS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic              step,
  input  logic [7:0]        wdata,
  output logic [7:0]        ptr_lo,
  output logic [7:0]        ptr_hi,
  output logic [ADDR_W-1:0] addr,
  output logic              rd_mode,
  output logic [ADDR_W-1:0] load_addr,
  output logic              load_rd_mode
);
  localparam int HI_W = ADDR_W - 8;

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  logic [ADDR_W-1:0] addr_nx;

  assign addr     = {ptr_hi[HI_W-1:0], ptr_lo};
  assign rd_mode  = ptr_hi[FLAG_POS];
  assign addr_nx  = step_addr(addr);

  // Pointer as it will be after the current load.
  assign load_addr    = ld_lo ? {ptr_hi[HI_W-1:0], wdata} : {wdata[HI_W-1:0], ptr_lo};
  assign load_rd_mode = ld_hi ? wdata[FLAG_POS] : ptr_hi[FLAG_POS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_lo <= '0;
      ptr_hi <= '0;
    end else if (ld_lo) begin
      ptr_lo <= wdata;
    end else if (ld_hi) begin
      ptr_hi <= wdata;
    end else if (step) begin
      ptr_lo            <= addr_nx[7:0];
      ptr_hi[HI_W-1:0]  <= addr_nx[ADDR_W-1:8];
    end
  end
endmodule

// File: rtl/bufwin_ram.sv
module bufwin_ram #(
  parameter int ADDR_W = 11,
  parameter int NRD    = 3
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         waddr,
  input  logic [7:0]                wdata,
  input  logic [NRD-1:0][ADDR_W-1:0] raddr,
  output logic [NRD-1:0][7:0]       rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar i = 0; i < NRD; i++) begin : g_rport
    assign rdata[i] = mem[raddr[i]];
  end
endmodule

// File: rtl/bufwin_prefetch.sv
module bufwin_prefetch #(
  parameter int LANES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [LANES-1:0][7:0] din,
  output logic [LANES*8-1:0]    word
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk) begin
      if (!rst_n)    lane_q <= '0;
      else if (load) lane_q <= din[i];
    end
    assign word[i*8 +: 8] = lane_q;
  end
endmodule

// File: rtl/bufwin_top.sv
module bufwin_top #(
  parameter int ADDR_W = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  host_addr,
  input  logic        host_rd,
  input  logic        host_wr,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  output logic [15:0] prefetch_word
);
  import bufwin_pkg::*;

  localparam int NRD = 3;

  // Named internal events, also watched by the checker.
  logic [1:0]        rise;
  logic              wr_ev, rd_ev;
  logic              st_ev, drop_ev, rd_data_ev, inc_ev;
  logic              ld_lo, ld_hi, ptr_ld, pf_ld;
  logic [7:0]        ptr_lo, ptr_hi;
  logic [ADDR_W-1:0] ptr_addr, load_addr;
  logic              rd_mode, load_rd_mode;
  logic [6:0]        cmd_q;
  logic [7:0]        rdata_q;
  logic [NRD-1:0][ADDR_W-1:0] ram_ra;
  logic [NRD-1:0][7:0]        ram_rd;

  bufwin_strobe #(.N(2)) strobe_i (
    .clk(clk), .rst_n(rst_n),
    .strobe({host_wr, host_rd}),
    .rise(rise)
  );

  assign wr_ev      = rise[1];
  assign rd_ev      = rise[0] & ~rise[1];
  assign st_ev      = wr_ev & is_data_port(host_addr) & ~rd_mode;
  assign drop_ev    = wr_ev & is_data_port(host_addr) & rd_mode;
  assign rd_data_ev = rd_ev & is_data_port(host_addr);
  assign inc_ev     = st_ev | rd_data_ev;
  assign ld_lo      = wr_ev & (host_addr == OFS_PTR_LO);
  assign ld_hi      = wr_ev & (host_addr == OFS_PTR_HI);
  assign ptr_ld     = ld_lo | ld_hi;
  assign pf_ld      = ptr_ld & load_rd_mode;

  bufwin_ptr #(.ADDR_W(ADDR_W), .FLAG_POS(FLAG_BIT)) ptr_i (
    .clk(clk), .rst_n(rst_n),
    .ld_lo(ld_lo), .ld_hi(ld_hi), .step(inc_ev),
    .wdata(host_wdata),
    .ptr_lo(ptr_lo), .ptr_hi(ptr_hi), .addr(ptr_addr),
    .rd_mode(rd_mode),
    .load_addr(load_addr), .load_rd_mode(load_rd_mode)
  );

  assign ram_ra[0] = ptr_addr;
  assign ram_ra[1] = load_addr;
  assign ram_ra[2] = load_addr + ADDR_W'(1);

  bufwin_ram #(.ADDR_W(ADDR_W), .NRD(NRD)) ram_i (
    .clk(clk), .we(st_ev), .waddr(ptr_addr), .wdata(host_wdata),
    .raddr(ram_ra), .rdata(ram_rd)
  );

  bufwin_prefetch #(.LANES(2)) pf_i (
    .clk(clk), .rst_n(rst_n), .load(pf_ld),
    .din({ram_rd[2], ram_rd[1]}),
    .word(prefetch_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                             cmd_q <= '0;
    else if (wr_ev && host_addr == OFS_CMD) cmd_q <= host_wdata[7:1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_ev) begin
      if (is_data_port(host_addr))        rdata_q <= ram_rd[0];
      else if (host_addr == OFS_PTR_LO)   rdata_q <= ptr_lo;
      else if (host_addr == OFS_PTR_HI)   rdata_q <= ptr_hi;
      else if (host_addr == OFS_CMD)      rdata_q <= cmd_view(cmd_q);
      else                                rdata_q <= '0;
    end
  end

  assign host_rdata = rdata_q;
endmodule

// File: rtl/bufwin_chk.sv
module bufwin_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        host_addr,
  input logic [7:0]        host_rdata,
  input logic [15:0]       prefetch_word,
  input logic [ADDR_W-1:0] ptr_addr,
  input logic [7:0]        ptr_hi,
  input logic              inc_ev,
  input logic              drop_ev,
  input logic              rd_ev,
  input logic              ptr_ld,
  input logic              load_rd_mode
);
  localparam int HI_W = ADDR_W - 8;

  // R3 R4
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_ev |=> ptr_addr == ADDR_W'($past(ptr_addr) + ADDR_W'(1)));

  // R8
  one_step_per_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_ev |=> !inc_ev);

  // R6
  dropped_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |=> ($stable(ptr_addr) && $stable(ptr_hi)));

  // R7
  upper_bits_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_ev |=> ptr_hi[7:HI_W] == $past(ptr_hi[7:HI_W]));

  // R9
  busy_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && host_addr == 4'h0) |=> host_rdata[0] == 1'b0);

  // R11
  prefetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_ld && !load_rd_mode) |=> $stable(prefetch_word));
endmodule

bind bufwin_top bufwin_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rdata(host_rdata),
  .prefetch_word(prefetch_word), .ptr_addr(ptr_addr), .ptr_hi(ptr_hi),
  .inc_ev(inc_ev), .drop_ev(drop_ev), .rd_ev(rd_ev), .ptr_ld(ptr_ld),
  .load_rd_mode(load_rd_mode)
);

// File: tb/bufwin_top_tb_top.sv
module bufwin_top_tb_top;
  localparam int ADDR_W = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  host_addr = '0;
  logic        host_rd = 1'b0;
  logic        host_wr = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic [15:0] prefetch_word;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bufwin_top #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .prefetch_word(prefetch_word)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input int hold = 1);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    repeat (hold) @(negedge clk);
    host_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d, input int hold = 1);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    repeat (hold) @(negedge clk);
    d = host_rdata;
    host_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 prefetch", prefetch_word, 16'h0000);
    rd(4'h6, v); check("R1 ptr lo", v, 8'h00);
    rd(4'h7, v); check("R1 ptr hi", v, 8'h00);
    rd(4'h0, v); check("R1 cmd", v, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(4'h6, 8'h34); wr(4'h7, 8'hC1);
    rd(4'h6, v); check("R2 ptr lo", v, 8'h34);
    rd(4'h7, v); check("R2 ptr hi", v, 8'hC1);
    wr(4'h0, 8'hFF);
    rd(4'h0, v); check("R9 cmd busy bit", v, 8'hFE);
  endtask

  task automatic t_stream();
    logic [7:0] v, w;
    wr(4'h7, 8'h00); wr(4'h6, 8'h10);
    wr(4'h8, 8'h11); wr(4'h9, 8'h22); wr(4'hA, 8'h33); wr(4'hB, 8'h44);
    rd(4'h6, v); check("R3 ptr after 4 stores", v, 8'h14);
    wr(4'h6, 8'h10);
    rd(4'h8, v); rd(4'h9, w); check("R10 R4 halfword ports 8/9", {w, v}, 16'h2211);
    rd(4'hA, v); rd(4'hB, w); check("R10 R4 halfword ports A/B", {w, v}, 16'h4433);
    rd(4'h6, v); check("R4 ptr after 4 reads", v, 8'h14);
  endtask

  task automatic t_prefetch();
    logic [7:0] v;
    wr(4'h6, 8'h11); wr(4'h7, 8'h20);
    check("R5 prefetch via hi write", prefetch_word, 16'h3322);
    rd(4'h6, v); check("R5 no advance on load", v, 8'h11);
    wr(4'h6, 8'h12);
    check("R5 prefetch via lo write", prefetch_word, 16'h4433);
    wr(4'h8, 8'h99);
    rd(4'h6, v); check("R6 ptr unchanged by write in read mode", v, 8'h12);
    rd(4'h8, v); check("R6 R4 buffer unchanged, read in read mode", v, 8'h33);
    wr(4'h7, 8'h00);
    check("R11 prefetch kept on flag-clear load", prefetch_word, 16'h4433);
  endtask

  task automatic t_wrap();
    logic [7:0] v, w;
    wr(4'h7, 8'hC1); wr(4'h6, 8'hFF);
    wr(4'h8, 8'h5A);
    rd(4'h6, v); check("R7 lo wraps", v, 8'h00);
    rd(4'h7, v); check("R7 hi upper bits kept", v, 8'hC0);
    wr(4'h9, 8'hA5);
    wr(4'h7, 8'hC1); wr(4'h6, 8'hFF);
    rd(4'h8, v); rd(4'h9, w); check("R7 R10 read across wrap", {w, v}, 16'hA55A);
    wr(4'h6, 8'hFF); wr(4'h7, 8'hE1);
    check("R7 R5 prefetch across wrap", prefetch_word, 16'hA55A);
  endtask

  task automatic t_held();
    logic [7:0] v;
    wr(4'h7, 8'h00); wr(4'h6, 8'h40);
    wr(4'h8, 8'h77, 4);
    rd(4'h6, v); check("R8 held write one step", v, 8'h41);
    wr(4'h6, 8'h40);
    rd(4'hA, v, 3); check("R8 held read data", v, 8'h77);
    rd(4'h6, v); check("R8 held read one step", v, 8'h41);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_stream();
    t_prefetch();
    t_wrap();
    t_held();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule